// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Synthesizer

This block turns a fixed reference clock into a square wave whose rate is set by a 16-bit control word. On every reference clock it adds an increment to a 16-bit phase register. The top bit of that register is the output wave, so the output rate is the increment divided by 2^16, times the reference rate.

The increment is derived from the control word. A word below 0x8000 is used as it is. A word of 0x8000 or above is replaced by its 16-bit two's complement. The fastest useful setting is 32768, which toggles the output every clock, and the slowest is 1.

A one-clock tick accompanies every low-to-high step of the wave, so downstream pulse-width logic can use it as a clock enable. The word is written as two bytes. The high byte only goes into a holding register. The low-byte write then commits both halves together, so the phase register never sees a half-updated word.

Top module: `nco_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wave_out and tick_out are 0 and the active word is 0.
- R2: A write with wr_sel=1 stores wr_data as the pending high byte only; the active word, and with it wave_out and tick_out, is not changed by it.
- R3: A write with wr_sel=0 makes the active word {pending high byte, wr_data} at that clock edge; the phase register uses it from the next edge on; the pending high byte is kept for later low-byte writes.
- R4: The increment is the active word when the word is below 0x8000, and (0x10000 - word) mod 0x10000 otherwise, so 0xC000 runs at the same rate as 0x4000.
- R5: On each clock with a nonzero active word, the 16-bit phase register adds the increment modulo 2^16, and wave_out is bit 15 of the phase register.
- R6: tick_out is high for exactly one cycle when wave_out is 1 and was 0 in the previous cycle, and is never high in two consecutive cycles.
- R7: An active word of 0 clears the phase register at the next edge; after that wave_out stays low and tick_out stays 0.
- R8: A power-of-two word 2^k (k at most 15) gives a wave of period 2^(16-k) cycles that is high for exactly half of them.
- R9: Word 0x8000 (increment 32768) makes wave_out alternate every clock, with a tick every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte select: 1 writes the pending high byte, 0 writes the low byte and commits |
| wr_data | input | 8 | Byte written |
| wave_out | output | 1 | Square wave, the top bit of the phase register |
| tick_out | output | 1 | One-cycle pulse on each rising step of wave_out |

## Verification
The reference model is fed these words:
- 0x4000 and 0xC000, whose tick counts must match; this tells the two's-complement folding apart from plain use of the word.
- 0x8000, which tells apart a wrapping add from a saturating one.
- 0x0123 and 0xFFFF, which are odd increments and expose carry errors in the phase add.
- 0x8001, which is a near-maximum folded word.
- Zero, which checks the clear.

A high-byte write with no low byte after it shows whether commits are held back until the low byte arrives. A low-byte write that reuses the pending high byte shows whether that byte is kept after a commit.

// File: rtl/nco_pkg.sv
package nco_pkg;
  parameter int NCO_W  = 16;
  parameter int BYTE_W = 8;

  typedef logic [NCO_W-1:0] word_t;

  // Fold a control word into the increment added to the phase register.
  function automatic word_t fold_incr(input word_t w);
    if (w[NCO_W-1]) return ~w + word_t'(1);
    else            return w;
  endfunction
endpackage

// File: rtl/nco_word_loader.sv
module nco_word_loader
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] pend_hi,
  output word_t             active_word,
  output logic              commit
);
  localparam int HI_W = NCO_W - BYTE_W;

  assign commit = wr_en && !wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_hi     <= '0;
      active_word <= '0;
    end else begin
      if (wr_en && wr_sel) pend_hi <= wr_data;
      if (commit)          active_word <= {pend_hi[HI_W-1:0], wr_data};
    end
  end
endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum
  import nco_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t active_word,
  output word_t incr,
  output word_t phase
);
  assign incr = fold_incr(active_word);

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase <= '0;
    else if (active_word == '0) phase <= '0;
    else                        phase <= phase + incr;
  end
endmodule

// File: rtl/nco_edge_tick.sv
module nco_edge_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic prev_level,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (!rst_n) prev_level <= 1'b0;
    else        prev_level <= level;
  end

  assign tick = level && !prev_level;
endmodule

// File: rtl/nco_gen.sv
module nco_gen
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wave_out,
  output logic              tick_out
);
  localparam int MSB = NCO_W - 1;

  logic [BYTE_W-1:0] pend_hi;
  word_t             active_word;
  word_t             incr;
  word_t             phase;
  logic              commit;
  logic              prev_wave;

  nco_word_loader u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .pend_hi     (pend_hi),
    .active_word (active_word),
    .commit      (commit)
  );

  nco_phase_accum u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_word (active_word),
    .incr        (incr),
    .phase       (phase)
  );

  assign wave_out = phase[MSB];

  nco_edge_tick u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (wave_out),
    .prev_level (prev_wave),
    .tick       (tick_out)
  );
endmodule

// File: rtl/nco_gen_chk.sv
module nco_gen_chk
  import nco_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] pend_hi,
  input word_t             active_word,
  input word_t             incr,
  input word_t             phase,
  input logic              wave_out,
  input logic              tick_out
);
  // R3
  commit_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> active_word == {$past(pend_hi), $past(wr_data)});

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> $stable(active_word));

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_word != '0) |=> phase == word_t'($past(phase) + $past(incr)));

  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out);

  // R6
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> (wave_out && !$past(wave_out)));

  // R7
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_word == '0) |=> (!wave_out && !tick_out));
endmodule

bind nco_gen nco_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .pend_hi     (pend_hi),
  .active_word (active_word),
  .incr        (incr),
  .phase       (phase),
  .wave_out    (wave_out),
  .tick_out    (tick_out)
);

// File: tb/nco_gen_bench.sv
module nco_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wave_out, tick_out;

  always #2.5 clk = ~clk;

  nco_gen u_nco_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wave_out(wave_out), .tick_out(tick_out)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  // Behavioural reference model
  int m_hi, m_word, m_acc, m_prev;

  function automatic int step_of(int w);
    if (w < 32768) return w;
    return (65536 - w) % 65536;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int nacc;
    cyc++;
    if (!rst_n) begin
      m_hi = 0; m_word = 0; m_acc = 0; m_prev = 0;
    end else begin
      nacc = (m_word == 0) ? 0 : (m_acc + step_of(m_word)) % 65536;
      m_prev = m_acc / 32768;
      m_acc = nacc;
      if (wr_en && wr_sel) m_hi = wr_data;
      if (wr_en && !wr_sel) m_word = m_hi * 256 + wr_data;
    end
  end

  // Compare on every clock, half a period after the edge.
  always @(negedge clk) begin
    int ewave, etick;
    if (rst_n && !finished) begin
      ewave = m_acc / 32768;
      etick = (ewave == 1 && m_prev == 0) ? 1 : 0;
      check(wave_out == ewave[0], "R5 wave", wave_out, ewave);
      check(tick_out == etick[0], "R6 tick", tick_out, etick);
    end
  end

  task automatic wr(bit sel, int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int w);
    wr(1'b1, w / 256);
    wr(1'b0, w % 256);
  endtask

  task automatic count(int n, output int highs, output int ticks);
    highs = 0; ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += wave_out;
      ticks += tick_out;
    end
  endtask

  initial begin
    int h, t, last;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wave_out == 1'b0 && tick_out == 1'b0, "R1 reset outputs", {wave_out, tick_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wave_out == 1'b0 && tick_out == 1'b0, "R1 after reset", {wave_out, tick_out}, 0);

    // R2: high byte alone changes nothing
    wr(1'b1, 8'h40);
    count(40, h, t);
    check(h == 0, "R2 highs after high-byte write", h, 0);
    check(t == 0, "R2 ticks after high-byte write", t, 0);

    // R3, R8: low byte commits 0x4000 -> period 4, half high
    wr(1'b0, 8'h00);
    repeat (4) @(negedge clk);
    count(64, h, t);
    check(h == 32, "R8 highs for 0x4000", h, 32);
    check(t == 16, "R8 ticks for 0x4000", t, 16);

    // R9: 0x8000 toggles every cycle
    load(16'h8000);
    repeat (3) @(negedge clk);
    last = wave_out;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(wave_out != last[0], "R9 toggle", wave_out, !last[0]);
      last = wave_out;
    end
    count(32, h, t);
    check(t == 16, "R9 ticks for 0x8000", t, 16);

    // R4: 0xC000 folds to 0x4000
    load(16'hC000);
    repeat (4) @(negedge clk);
    count(64, h, t);
    check(t == 16, "R4 ticks for 0xC000", t, 16);
    check(h == 32, "R4 highs for 0xC000", h, 32);

    // R5: odd and folded words, compared by the model each cycle
    load(16'h0123);
    repeat (300) @(negedge clk);
    load(16'hFFFF);
    repeat (100) @(negedge clk);
    load(16'h8001);
    repeat (100) @(negedge clk);

    // R3: low byte reuses kept high byte 0x80 -> 0x8000
    wr(1'b0, 8'h00);
    repeat (3) @(negedge clk);
    count(32, h, t);
    check(t == 16, "R3 kept high byte", t, 16);

    // R8: 0x1000 -> period 16, 8 high
    load(16'h1000);
    repeat (20) @(negedge clk);
    count(64, h, t);
    check(h == 32, "R8 highs for 0x1000", h, 32);
    check(t == 4, "R8 ticks for 0x1000", t, 4);

    // R7: zero word silences output
    load(16'h0000);
    @(negedge clk);
    count(50, h, t);
    check(h == 0, "R7 highs with zero word", h, 0);
    check(t == 0, "R7 ticks with zero word", t, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule